// File: doc/BRIEF.md
# Non-Blocking Load Scoreboard

This unit sits beside the decode stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory access, write-back). It lets a load leave decode without waiting for its data. It does this by tracking which of the sixteen 4-bit-addressed general-purpose registers still wait on a load. Four load slots hold the outstanding loads. Each slot keeps a busy flag and the register the load will write.

The instruction in decode arrives on a valid/ready handshake. It presents up to two source registers and one destination register, each with its own use flag, plus a flag that marks a load. In the same cycle the scoreboard lowers `dec_ready` if one of these holds:
- a used source register belongs to a pending load;
- the destination register belongs to a pending load;
- the instruction is a load and no slot is free.

An instruction issues on a cycle where `dec_valid` and `dec_ready` are both high. While `dec_ready` is low, decode must hold the instruction and its fields unchanged. An issuing load gets the lowest-numbered free slot, and that slot number appears on `ld_tag`.

Memory returns loads in any order, each with its slot tag, on `cmp_valid`/`cmp_tag`. The return path has no ready: the scoreboard accepts every return in the cycle it is presented. A return acts in the same cycle. It releases its register for the hazard check and its slot for allocation at once.

Top module: `ldsb_top`

## Requirements
- R1: After reset every slot is free and no register is pending, so any instruction, load or not, is accepted at once.
- R2: An instruction whose used source 0 or source 1 register is the destination of a pending load sees `dec_ready` low, and `stall` high if `dec_valid` is high.
- R3: A source register whose use flag is low never causes a stall, even if it matches a pending register.
- R4: An instruction that writes a register (`dst_use` high or `dec_is_load` high) stalls while that register is pending, so two loads never wait on the same register.
- R5: With all four slots busy and no return in the cycle, a load stalls. A non-load with no register conflict still issues.
- R6: An issued load takes the lowest-numbered free slot. `ld_tag` (0 to 3) shows that slot number in the issue cycle.
- R7: A return with tag T frees slot T and clears only that slot's pending register. Returns may arrive in any order.
- R8: A return in the same cycle as a dependent instruction removes the hazard in that cycle. Its slot may be given to a load issuing in that same cycle.
- R9: A return whose tag names a free slot has no effect on pending registers or on the choice of slots.
- R10: Nothing is allocated unless `dec_valid` and `dec_ready` are both high. A presented load that is not accepted leaves all slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds a valid instruction |
| dec_ready | output | 1 | No hazard; instruction may issue this cycle |
| dec_is_load | input | 1 | Instruction is a load to `dst_reg` |
| src0_use | input | 1 | Source 0 field is read |
| src0_reg | input | 4 | Source 0 register number |
| src1_use | input | 1 | Source 1 field is read |
| src1_reg | input | 4 | Source 1 register number |
| dst_use | input | 1 | Destination field is written |
| dst_reg | input | 4 | Destination register number |
| stall | output | 1 | `dec_valid` high and hazard present |
| ld_tag | output | 2 | Slot assigned to the load issuing this cycle |
| cmp_valid | input | 1 | A load return is presented |
| cmp_tag | input | 2 | Slot tag of the returning load |

## Verification
`stall`, `dec_ready` and `ld_tag` are combinational in the current inputs and the slot state. The bench therefore samples them in the same cycle it drives them: inputs change on the falling edge and are read 2 ns later, before the next rising edge. A slot change, whether an allocation or a return, first shows in the decision of the following cycle. The bench's reference model updates on the same rising edge, so each expected value is based on exactly the state the design holds. The same-cycle bypass cases (R8) are checked in the cycle where the return is presented.

// File: rtl/ldsb_pkg.sv
package ldsb_pkg;
  parameter int NUM_SLOTS = 4;
  parameter int REG_W     = 4;
  localparam int TAG_W    = $clog2(NUM_SLOTS);
  localparam int NUM_QRY  = 3;   // src0, src1, dst
  typedef logic [REG_W-1:0] reg_id_t;
  typedef logic [TAG_W-1:0] slot_tag_t;
endpackage

// File: rtl/ldsb_pick_free.sv
module ldsb_pick_free #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic [N-1:0]  free_vec,
  output logic          any_free,
  output logic [TW-1:0] idx
);
  assign any_free = |free_vec;

  // lowest index wins: scan from the top down
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) idx = TW'(i);
    end
  end
endmodule

// File: rtl/ldsb_dep_check.sv
module ldsb_dep_check #(
  parameter int N  = 4,
  parameter int RW = 4
) (
  input  logic [N-1:0]         live,
  input  logic [N-1:0][RW-1:0] slot_reg,
  input  logic [RW-1:0]        qreg,
  input  logic                 qen,
  output logic                 hit
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = live[i] && (slot_reg[i] == qreg);
  end

  assign hit = qen && (|match);
endmodule

// File: rtl/ldsb_slot_table.sv
module ldsb_slot_table #(
  parameter int N  = 4,
  parameter int RW = 4,
  parameter int TW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic [TW-1:0]        alloc_idx,
  input  logic [RW-1:0]        alloc_reg,
  input  logic                 cmp_valid,
  input  logic [TW-1:0]        cmp_tag,
  output logic [N-1:0]         slot_vld,
  output logic [N-1:0][RW-1:0] slot_reg
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[i] <= 1'b0;
        slot_reg[i] <= '0;
      end else begin
        // a return clears the slot; a new load in the same cycle takes precedence
        if (cmp_valid && cmp_tag == TW'(i)) slot_vld[i] <= 1'b0;
        if (alloc_en && alloc_idx == TW'(i)) begin
          slot_vld[i] <= 1'b1;
          slot_reg[i] <= alloc_reg;
        end
      end
    end
  end

  // R6: an accepted load is recorded in the chosen slot
  a_r6_alloc_records: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> slot_vld[$past(alloc_idx)] && slot_reg[$past(alloc_idx)] == $past(alloc_reg));

  // R7: a return frees its slot unless the slot is reused at once
  a_r7_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !(alloc_en && alloc_idx == cmp_tag)) |=> !slot_vld[$past(cmp_tag)]);

  // R10: without an allocation the busy count never grows
  a_r10_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_en |=> $countones(slot_vld) <= $countones($past(slot_vld)));

  // R4: no two busy slots wait on the same register
  for (genvar a = 0; a < N; a++) begin : g_pa
    for (genvar b = a + 1; b < N; b++) begin : g_pb
      a_r4_unique_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_vld[a] && slot_vld[b] && slot_reg[a] == slot_reg[b]));
    end
  end
endmodule

// File: rtl/ldsb_top.sv
module ldsb_top
  import ldsb_pkg::*;
#(
  parameter int N  = NUM_SLOTS,
  parameter int RW = REG_W,
  localparam int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  output logic          dec_ready,
  input  logic          dec_is_load,
  input  logic          src0_use,
  input  logic [RW-1:0] src0_reg,
  input  logic          src1_use,
  input  logic [RW-1:0] src1_reg,
  input  logic          dst_use,
  input  logic [RW-1:0] dst_reg,
  output logic          stall,
  output logic [TW-1:0] ld_tag,
  input  logic          cmp_valid,
  input  logic [TW-1:0] cmp_tag
);
  logic [N-1:0]         slot_vld;
  logic [N-1:0][RW-1:0] slot_reg;
  logic [N-1:0]         ret_hit;
  logic [N-1:0]         live;
  logic                 any_free;
  logic [TW-1:0]        pick_idx;
  logic                 alloc_en;
  logic                 hazard;
  logic [NUM_QRY-1:0]   q_en;
  logic [NUM_QRY-1:0][RW-1:0] q_reg;
  logic [NUM_QRY-1:0]   q_hit;

  // return bypass: a returning slot no longer counts as pending
  for (genvar i = 0; i < N; i++) begin : g_live
    assign ret_hit[i] = cmp_valid && (cmp_tag == TW'(i));
    assign live[i]    = slot_vld[i] && !ret_hit[i];
  end

  assign q_en  = {dst_use | dec_is_load, src1_use, src0_use};
  assign q_reg = {dst_reg, src1_reg, src0_reg};

  for (genvar q = 0; q < NUM_QRY; q++) begin : g_qry
    ldsb_dep_check #(.N(N), .RW(RW)) u_dep (
      .live     (live),
      .slot_reg (slot_reg),
      .qreg     (q_reg[q]),
      .qen      (q_en[q]),
      .hit      (q_hit[q])
    );
  end

  ldsb_pick_free #(.N(N), .TW(TW)) u_pick (
    .free_vec (~live),
    .any_free (any_free),
    .idx      (pick_idx)
  );

  assign hazard    = (|q_hit) || (dec_is_load && !any_free);
  assign dec_ready = !hazard;
  assign stall     = dec_valid && hazard;
  assign alloc_en  = dec_valid && dec_ready && dec_is_load;
  assign ld_tag    = pick_idx;

  ldsb_slot_table #(.N(N), .RW(RW), .TW(TW)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_idx (pick_idx),
    .alloc_reg (dst_reg),
    .cmp_valid (cmp_valid),
    .cmp_tag   (cmp_tag),
    .slot_vld  (slot_vld),
    .slot_reg  (slot_reg)
  );

  // R5: a full table with no return blocks a presented load
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_is_load && (&slot_vld) && !cmp_valid) |-> stall);

  // R6: the tag handed out names a slot that was free or returning
  a_r6_tag_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (!slot_vld[ld_tag] || (cmp_valid && cmp_tag == ld_tag)));
endmodule

// File: tb/ldsb_top_tb_top.sv
module ldsb_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, dec_is_load = 0, src0_use = 0, src1_use = 0, dst_use = 0;
  logic [3:0] src0_reg = 0, src1_reg = 0, dst_reg = 0;
  logic cmp_valid = 0;
  logic [1:0] cmp_tag = 0;
  logic dec_ready, stall;
  logic [1:0] ld_tag;

  int total = 0, bad = 0;
  bit finished = 0;
  bit mv [4];
  logic [3:0] mr [4];

  always #4 clk = ~clk;

  ldsb_top dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_is_load(dec_is_load), .src0_use(src0_use), .src0_reg(src0_reg),
    .src1_use(src1_use), .src1_reg(src1_reg), .dst_use(dst_use), .dst_reg(dst_reg),
    .stall(stall), .ld_tag(ld_tag), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
  );

  // reference model
  function automatic bit m_live(int i);
    return mv[i] && !(cmp_valid && cmp_tag == 2'(i));
  endfunction
  function automatic bit m_pend(logic [3:0] r);
    for (int i = 0; i < 4; i++) if (m_live(i) && mr[i] == r) return 1'b1;
    return 1'b0;
  endfunction
  function automatic bit m_haz();
    bit fr = 0;
    for (int i = 0; i < 4; i++) if (!m_live(i)) fr = 1;
    return (src0_use && m_pend(src0_reg)) || (src1_use && m_pend(src1_reg)) ||
           ((dst_use || dec_is_load) && m_pend(dst_reg)) || (dec_is_load && !fr);
  endfunction
  function automatic logic [1:0] m_tag();
    for (int i = 0; i < 4; i++) if (!m_live(i)) return 2'(i);
    return 2'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin mv[i] = 0; mr[i] = 0; end
    end else begin
      bit iss;
      logic [1:0] t;
      iss = dec_valid && dec_is_load && !m_haz();
      t = m_tag();
      if (cmp_valid) mv[cmp_tag] = 0;
      if (iss) begin mv[t] = 1; mr[t] = dst_reg; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle of inputs on the falling edge, settle before the rising edge
  task automatic cyc(input bit dv, input bit ld, input bit s0u, input int s0,
                     input bit s1u, input int s1, input bit du, input int d,
                     input bit cv, input int ct);
    @(negedge clk);
    dec_valid = dv; dec_is_load = ld;
    src0_use = s0u; src0_reg = 4'(s0); src1_use = s1u; src1_reg = 4'(s1);
    dst_use = du; dst_reg = 4'(d); cmp_valid = cv; cmp_tag = 2'(ct);
    #2;
  endtask

  task automatic exp_st(input string req, input bit s);
    chk(stall === s, req, int'(stall), int'(s));
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: fresh state, reads and a load proceed
    cyc(1,0, 1,1, 1,2, 1,3, 0,0);  exp_st("R1", 0);
    chk(dec_ready === 1'b1, "R1", int'(dec_ready), 1);
    // R6: fill slots in order, loads to r1..r4
    for (int k = 0; k < 4; k++) begin
      cyc(1,1, 0,0, 0,0, 1,k+1, 0,0);
      exp_st("R6", 0);
      chk(ld_tag === 2'(k), "R6", int'(ld_tag), k);
    end
    cyc(1,1, 0,0, 0,0, 1,5, 0,0);   exp_st("R5", 1);
    cyc(1,0, 1,9, 0,0, 1,10, 0,0);  exp_st("R5", 0);
    cyc(1,0, 1,2, 0,0, 0,0, 0,0);   exp_st("R2", 1);
    cyc(1,0, 1,9, 1,3, 0,0, 0,0);   exp_st("R3", 1);
    cyc(1,0, 1,9, 0,3, 0,0, 0,0);   exp_st("R3", 0);
    cyc(1,0, 0,0, 0,0, 1,4, 0,0);   exp_st("R4", 1);
    // R8: return of slot 2 (r3) bypasses to a reader of r3
    cyc(1,0, 1,3, 0,0, 0,0, 1,2);   exp_st("R8", 0);
    cyc(1,0, 1,3, 0,0, 0,0, 0,0);   exp_st("R7", 0);
    cyc(1,0, 1,1, 0,0, 0,0, 0,0);   exp_st("R7", 1);
    // R9: return to free slot 2 changes nothing
    cyc(1,0, 1,1, 0,0, 0,0, 1,2);   exp_st("R9", 1);
    // R10: load not presented allocates nothing
    cyc(0,1, 0,0, 0,0, 1,6, 0,0);   exp_st("R10", 0);
    cyc(1,1, 0,0, 0,0, 1,6, 0,0);   exp_st("R10", 0);
    chk(ld_tag === 2'd2, "R10", int'(ld_tag), 2);
    // R8: full table, return of slot 0 lets a load take slot 0 at once
    cyc(1,1, 0,0, 0,0, 1,7, 1,0);   exp_st("R8", 0);
    chk(ld_tag === 2'd0, "R8", int'(ld_tag), 0);
    cyc(1,0, 1,7, 0,0, 0,0, 0,0);   exp_st("R2", 1);
    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      bit h;
      cyc(($urandom % 5) != 0, ($urandom % 3) == 0, $urandom % 2, $urandom % 8,
          $urandom % 2, $urandom % 8, $urandom % 2, $urandom % 8,
          ($urandom % 5) < 2, $urandom % 4);
      h = m_haz();
      chk(stall === (dec_valid && h), "R2", int'(stall), int'(dec_valid && h));
      chk(dec_ready === !h, "R4", int'(dec_ready), int'(!h));
      if (dec_valid && dec_is_load && !h)
        chk(ld_tag === m_tag(), "R6", int'(ld_tag), int'(m_tag()));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule